// File: doc/BRIEF.md
# Flash Access Violation Detector

This block sits beside a flash controller and inspects every access the processor makes to the flash array. There are three access kinds: a data write or erase on the external-data path, a data read on the code-read path, and an instruction fetch, which includes branch targets. For each one it checks four things. It checks the address against the lock-byte boundary. It checks a per-access denial signal from the security policy logic. It checks the supply-voltage monitor enable. It checks the program-store write-enable bit, which decides whether a write on the external-data path reaches flash at all.

When any rule is broken, the block sends one single-cycle error request to the reset controller and raises a flash-error cause flag. After that it disregards all further access strobes until the reset controller acknowledges. Several rules can be broken by the same access, and that access still yields exactly one request.

The control path is a three-state machine:
- `ST_IDLE` watches strobes.
- `ST_FIRE` drives the request for one cycle.
- `ST_HOLD` keeps the cause flag and waits for the acknowledge.

Its transitions are:
- IDLE→FIRE on a violating strobe.
- FIRE→HOLD when no acknowledge is present.
- FIRE→IDLE when an acknowledge arrives in the pulse cycle.
- HOLD→IDLE on acknowledge.
- IDLE→IDLE and HOLD→HOLD otherwise.

Top module: `flash_guard`

## Requirements
- R1: An access of kind 2'b00 (write/erase) with `store_wr_en`=1 and `acc_addr` strictly greater than `lock_addr` is a violation.
- R2: An access of kind 2'b01 (code-space data read) with `acc_addr` strictly greater than `lock_addr` is a violation.
- R3: An access of kind 2'b10 (instruction fetch) with `acc_addr` strictly greater than `lock_addr` is a violation.
- R4: An access whose address equals or lies below `lock_addr` breaks no boundary rule. With `sec_deny`=0 and `vmon_en`=1 it gives no error.
- R5: A flash access (kind 2'b01, kind 2'b10, or kind 2'b00 with `store_wr_en`=1) with `sec_deny`=1 is a violation at any address.
- R6: A write/erase (kind 2'b00, `store_wr_en`=1) with `vmon_en`=0 is a violation at any address. Reads and fetches do not depend on `vmon_en`.
- R7: Kind 2'b00 with `store_wr_en`=0 does not target flash. It never raises an error, whatever its address, `sec_deny` or `vmon_en`.
- R8: A violation sampled on the clock edge where `acc_valid`=1 makes `err_req` high for exactly the next cycle. With `acc_valid`=0 the access fields have no effect.
- R9: `err_flag` rises together with `err_req` and stays high until `rst_ack` is sampled high. While it is high, strobes produce no request. After the acknowledge, a new violation is reported again.
- R10: An access that breaks several rules at once yields a single one-cycle pulse.
- R11: After reset, `err_req` and `err_flag` are 0.
- R12: Kind 2'b11 is reserved and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, sampled on the rising edge |
| acc_kind | input | 2 | 00 write/erase, 01 code read, 10 fetch, 11 reserved |
| acc_addr | input | 16 | Access address |
| store_wr_en | input | 1 | Program-store write-enable bit |
| lock_addr | input | 16 | Lock-byte address (highest legal address) |
| sec_deny | input | 1 | Security policy denies this access |
| vmon_en | input | 1 | Supply-voltage monitor enabled |
| rst_ack | input | 1 | Reset controller acknowledge |
| err_req | output | 1 | One-cycle error/reset request |
| err_flag | output | 1 | Flash-error cause flag, held until acknowledge |

## Verification
A strobe that is sampled on rising edge k has its result on `err_req` and `err_flag` from edge k until edge k+1. The bench therefore drives on the falling edge, lets one rising edge pass, and compares at the next falling edge. The single-cycle pulse is confirmed by checking `err_req` low one further falling edge later. Acknowledge effects are checked the same way: the acknowledge is driven on a falling edge, and the outputs are compared one rising edge later.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'b00,
        ACC_CREAD = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FIRE = 2'b01,
        ST_HOLD = 2'b10
    } guard_state_e;

    typedef struct packed {
        logic bound;
        logic secur;
        logic supply;
    } viol_t;

endpackage

// File: rtl/fg_rule_eval.sv
module fg_rule_eval
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lock_addr,
    input  logic              store_wr_en,
    input  logic              sec_deny,
    input  logic              vmon_en,
    output viol_t             why,
    output logic              any_viol
);

    acc_kind_e k;
    logic      hits_flash;
    logic      is_flash_write;
    logic      past_lock;

    always_comb begin
        k              = acc_kind_e'(kind);
        past_lock      = (addr > lock_addr);
        hits_flash     = 1'b0;
        is_flash_write = 1'b0;
        unique case (k)
            ACC_WRITE: begin
                hits_flash     = store_wr_en;
                is_flash_write = store_wr_en;
            end
            ACC_CREAD: hits_flash = 1'b1;
            ACC_FETCH: hits_flash = 1'b1;
            ACC_RSVD:  hits_flash = 1'b0;
            default:   hits_flash = 1'b0;
        endcase
        why.bound  = hits_flash & past_lock;
        why.secur  = hits_flash & sec_deny;
        why.supply = is_flash_write & ~vmon_en;
        any_viol   = |why;
    end

    // R6: the supply rule only fires for a flash write
    always_comb begin
        if (why.supply) begin
            assert_supply_write_only_R6: assert (kind == 2'b00 && store_wr_en);
        end
    end

endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
    import flash_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic viol,
    input  logic ack,
    output logic req,
    output logic flag
);

    guard_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (strobe && viol) state_nx = ST_FIRE;
            ST_FIRE: state_nx = ack ? ST_IDLE : ST_HOLD;
            ST_HOLD: if (ack) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req  = 1'b0;
        flag = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FIRE: begin
                req  = 1'b1;
                flag = 1'b1;
            end
            ST_HOLD: flag = 1'b1;
            default: ;
        endcase
    end

    // R8 / R10: the request lasts a single cycle
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R8: a request is preceded by a violating strobe
    assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(strobe && viol));

    // R9: the flag holds until acknowledge, and strobes raise nothing meanwhile
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> (flag && !req));

    // R9: the request always comes with the flag
    assert_req_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> flag);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              store_wr_en,
    input  logic [ADDR_W-1:0] lock_addr,
    input  logic              sec_deny,
    input  logic              vmon_en,
    input  logic              rst_ack,
    output logic              err_req,
    output logic              err_flag
);

    viol_t why;
    logic  any_viol;

    fg_rule_eval #(.ADDR_W(ADDR_W)) u_rules (
        .kind        (acc_kind),
        .addr        (acc_addr),
        .lock_addr   (lock_addr),
        .store_wr_en (store_wr_en),
        .sec_deny    (sec_deny),
        .vmon_en     (vmon_en),
        .why         (why),
        .any_viol    (any_viol)
    );

    fg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (acc_valid),
        .viol   (any_viol),
        .ack    (rst_ack),
        .req    (err_req),
        .flag   (err_flag)
    );

    // R1: a flash write past the lock byte is reported
    assert_write_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !err_flag && acc_kind == 2'b00 && store_wr_en && acc_addr > lock_addr)
        |=> err_req);

    // R3: a fetch past the lock byte is reported
    assert_fetch_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !err_flag && acc_kind == 2'b10 && acc_addr > lock_addr) |=> err_req);

    // R4: a read or fetch at or below the lock byte, not denied, is legal
    assert_at_lock_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'b00 && acc_addr <= lock_addr && !sec_deny) |=> !err_req);

    // R7: a non-flash write never reports
    assert_ram_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b00 && !store_wr_en) |=> !err_req);

    // R12: the reserved kind never reports
    assert_reserved_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b11) |=> !err_req);

endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [15:0] acc_addr = '0;
    logic        store_wr_en = 1'b0;
    logic [15:0] lock_addr = 16'h8000;
    logic        sec_deny = 1'b0;
    logic        vmon_en = 1'b1;
    logic        rst_ack = 1'b0;
    logic        err_req;
    logic        err_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .store_wr_en(store_wr_en), .lock_addr(lock_addr),
        .sec_deny(sec_deny), .vmon_en(vmon_en), .rst_ack(rst_ack),
        .err_req(err_req), .err_flag(err_flag)
    );

    // {req_id[3:0], kind[1:0], addr[15:0], we, lock[15:0], sec, vmon, expect}
    localparam int NV = 16;
    localparam logic [41:0] VEC [0:NV-1] = '{
        {4'd1,  2'b00, 16'h8001, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b1}, // R1
        {4'd4,  2'b00, 16'h8000, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b0}, // R4
        {4'd4,  2'b00, 16'h1234, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b0}, // R4
        {4'd2,  2'b01, 16'h8001, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b1}, // R2
        {4'd4,  2'b01, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0}, // R4
        {4'd3,  2'b10, 16'hFFFF, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b1}, // R3
        {4'd4,  2'b10, 16'h7FFF, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0}, // R4
        {4'd5,  2'b01, 16'h0100, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b1}, // R5
        {4'd5,  2'b10, 16'h0100, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b1}, // R5
        {4'd5,  2'b00, 16'h0100, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b1}, // R5
        {4'd6,  2'b00, 16'h0100, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b1}, // R6
        {4'd6,  2'b01, 16'h0100, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0}, // R6
        {4'd7,  2'b00, 16'hFFFF, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b0}, // R7
        {4'd12, 2'b11, 16'hFFFF, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0}, // R12
        {4'd4,  2'b10, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0}, // R4
        {4'd1,  2'b00, 16'h0001, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1}  // R1
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [1:0] k, input logic [15:0] a, input logic we,
                          input logic [15:0] lk, input logic s, input logic v);
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; store_wr_en = we;
        lock_addr = lk; sec_deny = s; vmon_en = v;
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic acknowledge();
        rst_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        rst_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 err_req after reset", err_req, 1'b0);
        check("R11 err_flag after reset", err_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d err_req", v[41:38], i);
            strobe(v[37:36], v[35:20], v[19], v[18:3], v[2], v[1]);
            check(tag, err_req, v[0]);
            check($sformatf("R%0d vector %0d err_flag", v[41:38], i), err_flag, v[0]);
            if (v[0]) begin
                acknowledge();
                check("R9 flag cleared by ack", err_flag, 1'b0);
            end
        end

        // R8: no strobe, violating fields have no effect
        acc_valid = 1'b0; acc_kind = 2'b10; acc_addr = 16'hFFFF; lock_addr = 16'h0000;
        sec_deny = 1'b1; vmon_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 idle fields ignored", err_req, 1'b0);

        // R10: all three rules at once, one pulse
        strobe(2'b00, 16'hF000, 1'b1, 16'h1000, 1'b1, 1'b0);
        check("R10 multi-rule pulse", err_req, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R10 pulse one cycle", err_req, 1'b0);
        check("R9 flag held", err_flag, 1'b1);

        // R9: strobe while holding is ignored
        strobe(2'b10, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b1);
        check("R9 strobe ignored in hold", err_req, 1'b0);
        check("R9 flag still held", err_flag, 1'b1);
        acknowledge();
        check("R9 flag cleared", err_flag, 1'b0);
        strobe(2'b01, 16'h2000, 1'b0, 16'h1000, 1'b0, 1'b1);
        check("R9 new violation after ack", err_req, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R8 pulse ends", err_req, 1'b0);

        // R9: acknowledge arriving in the pulse cycle
        acknowledge();
        strobe(2'b10, 16'h3000, 1'b0, 16'h1000, 1'b0, 1'b1);
        check("R3 fetch past lock", err_req, 1'b1);
        acknowledge();
        check("R9 ack in pulse cycle clears flag", err_flag, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule